// File: doc/BRIEF.md
# Parallel Flash Erase and Program Sequencer

This block drives the byte-wide command protocol of a parallel NOR-style flash bank. On a start pulse it either erases the whole bank or programs every byte of the bank from a source memory. Each command is preceded by a two-write unlock preamble. Every bus write is followed by a programmable quiet period. The block waits for the internal operation to finish by reading offset zero twice and comparing the two values. Once the operation is finished it issues a reset-to-read command and reads the bank back to verify it.

The sequencer has one flash bus with an address, write data, a one-cycle write strobe and a one-cycle read strobe; read data returns one cycle after the strobe. Source bytes come through a read port that has one cycle of latency. When a run finishes, `done` pulses. Two error flags tell a clean finish apart from a completion timeout and from a verify mismatch.

Top module: `flash_prog_seq`

## Requirements
- R1: An erase issues exactly these writes, in this order, as (offset, byte): (0x555,0xAA), (0x2AA,0x55), (0x555,0x80), (0x555,0xAA), (0x2AA,0x55), (0x000,0x30). Completion polling follows the last of them.
- R2: A program run handles the bank bytes in ascending offset order. For byte i it writes (0x555,0xAA), (0x2AA,0x55), (0x555,0xA0), and then (i, source byte i). It then polls for completion before it moves to the next byte.
- R3: After the erase poll, or after the poll for the last programmed byte, exactly one write of 0xF0 to offset 0x000 is issued. No further writes occur in that run.
- R4: After every bus write the bus stays idle for SETTLE_CYC cycles. Two writes with no poll between them start exactly SETTLE_CYC+2 cycles apart.
- R5: Polling reads offset 0x000 twice in a row. The operation counts as finished when the two bytes are equal; when they differ, another pair of reads follows.
- R6: After POLL_LIMIT unequal read pairs the run ends with `err_timeout`=1 and `err_verify`=0. No further write or read is issued.
- R7: The erase verify reads offsets 0 to BANK_BYTES-1 in order, and each byte must be 0xFF. The first byte that differs ends the run with `err_verify`=1, and no further reads are issued.
- R8: The program verify reads offsets 0 to BANK_BYTES-1 in order, and each byte must equal its source byte. The first mismatch ends the run with `err_verify`=1. A clean run ends with both error flags at 0.
- R9: A start pulse that arrives while `busy`=1 is ignored: the current run's write sequence and its result do not change.
- R10: After reset `busy`, `done`, `fl_we` and `fl_re` are 0. `done` is high for exactly one cycle at the end of a run, and `busy` is 0 in that same cycle. The error flags keep their value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled only while idle |
| op_prog | input | 1 | Operation select: 0 erase, 1 program |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_timeout | output | 1 | Completion poll gave up |
| err_verify | output | 1 | Read-back mismatch |
| src_addr | output | IDX_W | Source byte index |
| src_data | input | 8 | Source byte, valid one cycle after src_addr |
| fl_addr | output | ADDR_W | Flash offset |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe, one cycle |
| fl_re | output | 1 | Flash read strobe, one cycle |
| fl_rdata | input | 8 | Flash read byte, valid one cycle after fl_re |

## Verification
The assertions assume three things about the flash side. Read data is held between read strobes. It answers a read one cycle after the strobe. It never needs a write strobe wider than one cycle. The bench flash model keeps to these. It registers each read, and while an internal operation is pending it flips a status bit on every read. It also decodes the command history, so it applies only a fully formed erase or program sequence. Start and the source data are driven on the falling edge. The source memory is held constant for the whole of each run.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ISSUE, ST_SETTLE,
    ST_PRD1, ST_PRD2, ST_PWAIT, ST_PCMP,
    ST_VRD, ST_VWAIT, ST_VCMP
  } fps_state_t;

  localparam logic [10:0] OFFS_KEY1 = 11'h555;
  localparam logic [10:0] OFFS_KEY2 = 11'h2AA;
  localparam logic [7:0]  CODE_KEY1 = 8'hAA;
  localparam logic [7:0]  CODE_KEY2 = 8'h55;
  localparam logic [7:0]  CODE_ERASE_ARM = 8'h80;
  localparam logic [7:0]  CODE_ERASE_GO  = 8'h30;
  localparam logic [7:0]  CODE_PROG      = 8'hA0;
  localparam logic [7:0]  CODE_READ_MODE = 8'hF0;
  localparam logic [7:0]  ERASED_BYTE    = 8'hFF;

  localparam logic [2:0] ERASE_RESET_STEP = 3'd6;
  localparam logic [2:0] PROG_RESET_STEP  = 3'd4;
endpackage

// File: rtl/fps_cmd_table.sv
module fps_cmd_table
  import fps_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 13
) (
  input  logic              prog,
  input  logic [2:0]        step,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        src_byte,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              poll_next,
  output logic              reset_cmd
);
  localparam logic [ADDR_W-1:0] A_KEY1 = ADDR_W'(OFFS_KEY1);
  localparam logic [ADDR_W-1:0] A_KEY2 = ADDR_W'(OFFS_KEY2);

  always_comb begin
    addr      = '0;
    data      = CODE_READ_MODE;
    poll_next = 1'b0;
    reset_cmd = 1'b0;
    if (!prog) begin
      case (step)
        3'd0: begin addr = A_KEY1; data = CODE_KEY1; end
        3'd1: begin addr = A_KEY2; data = CODE_KEY2; end
        3'd2: begin addr = A_KEY1; data = CODE_ERASE_ARM; end
        3'd3: begin addr = A_KEY1; data = CODE_KEY1; end
        3'd4: begin addr = A_KEY2; data = CODE_KEY2; end
        3'd5: begin addr = '0; data = CODE_ERASE_GO; poll_next = 1'b1; end
        default: reset_cmd = 1'b1;
      endcase
    end else begin
      case (step)
        3'd0: begin addr = A_KEY1; data = CODE_KEY1; end
        3'd1: begin addr = A_KEY2; data = CODE_KEY2; end
        3'd2: begin addr = A_KEY1; data = CODE_PROG; end
        3'd3: begin addr = ADDR_W'(idx); data = src_byte; poll_next = 1'b1; end
        default: reset_cmd = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fps_settle.sv
module fps_settle #(
  parameter int SETTLE_CYC = 250,
  localparam int CW = $clog2(SETTLE_CYC + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(SETTLE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  AST_SETTLE_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SETTLE_CYC)); // R4
endmodule

// File: rtl/fps_poll_ctr.sv
module fps_poll_ctr #(
  parameter int POLL_LIMIT = 1000000,
  localparam int PW = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_last = (cnt_q == PW'(POLL_LIMIT - 1));

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < PW'(POLL_LIMIT)); // R6
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BANK_BYTES = 8192,
  parameter int SETTLE_CYC = 250,
  parameter int POLL_LIMIT = 1000000,
  localparam int IDX_W = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_prog,
  output logic              busy,
  output logic              done,
  output logic              err_timeout,
  output logic              err_verify,
  output logic [IDX_W-1:0]  src_addr,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [7:0]        fl_rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BANK_BYTES - 1);

  fps_state_t        state_q;
  logic [2:0]        step_q;
  logic [IDX_W-1:0]  idx_q;
  logic              prog_q;
  logic [7:0]        poll_a_q;
  logic              busy_q, done_q, err_t_q, err_v_q;
  logic              we_q, re_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wdata_q;

  logic [ADDR_W-1:0] t_addr;
  logic [7:0]        t_data;
  logic              t_poll, t_reset;
  logic              dly_exp, poll_last;
  logic              poll_clr, poll_inc, poll_same, idx_last;
  logic [7:0]        verify_exp;

  fps_cmd_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .prog(prog_q), .step(step_q), .idx(idx_q), .src_byte(src_data),
    .addr(t_addr), .data(t_data), .poll_next(t_poll), .reset_cmd(t_reset)
  );

  fps_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .load(state_q == ST_ISSUE), .expired(dly_exp)
  );

  assign poll_same = (fl_rdata == poll_a_q);
  assign poll_clr  = (state_q == ST_SETTLE) && dly_exp && t_poll;
  assign poll_inc  = (state_q == ST_PCMP) && !poll_same && !poll_last;

  fps_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .at_last(poll_last)
  );

  assign idx_last   = (idx_q == LAST_IDX);
  assign verify_exp = prog_q ? src_data : ERASED_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      step_q   <= '0;
      idx_q    <= '0;
      prog_q   <= 1'b0;
      poll_a_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_t_q  <= 1'b0;
      err_v_q  <= 1'b0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else begin
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          prog_q  <= op_prog;
          step_q  <= '0;
          idx_q   <= '0;
          err_t_q <= 1'b0;
          err_v_q <= 1'b0;
          busy_q  <= 1'b1;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          we_q    <= 1'b1;
          addr_q  <= t_addr;
          wdata_q <= t_data;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (dly_exp) begin
          if (t_reset) begin
            idx_q   <= '0;
            state_q <= ST_VRD;
          end else if (t_poll) begin
            state_q <= ST_PRD1;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_PRD1: begin
          re_q    <= 1'b1;
          addr_q  <= '0;
          state_q <= ST_PRD2;
        end
        ST_PRD2: begin
          re_q    <= 1'b1;
          addr_q  <= '0;
          state_q <= ST_PWAIT;
        end
        ST_PWAIT: begin
          poll_a_q <= fl_rdata;
          state_q  <= ST_PCMP;
        end
        ST_PCMP: begin
          if (poll_same) begin
            if (!prog_q) begin
              step_q <= ERASE_RESET_STEP;
            end else if (idx_last) begin
              step_q <= PROG_RESET_STEP;
            end else begin
              idx_q  <= idx_q + 1'b1;
              step_q <= '0;
            end
            state_q <= ST_ISSUE;
          end else if (poll_last) begin
            err_t_q <= 1'b1;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PRD1;
          end
        end
        ST_VRD: begin
          re_q    <= 1'b1;
          addr_q  <= ADDR_W'(idx_q);
          state_q <= ST_VWAIT;
        end
        ST_VWAIT: state_q <= ST_VCMP;
        ST_VCMP: begin
          if (fl_rdata != verify_exp) begin
            err_v_q <= 1'b1;
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else if (idx_last) begin
            done_q  <= 1'b1;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_VRD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign err_timeout = err_t_q;
  assign err_verify  = err_v_q;
  assign src_addr    = idx_q;
  assign fl_addr     = addr_q;
  assign fl_wdata    = wdata_q;
  assign fl_we       = we_q;
  assign fl_re       = re_q;

  AST_WE_SETTLE: assert property (@(posedge clk) disable iff (rst)
    fl_we |=> !fl_we && !fl_re); // R4
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fl_we && !fl_re); // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    done |-> !(err_timeout && err_verify)); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(done) && $past(!busy) |-> $stable(err_timeout) && $stable(err_verify)); // R10
endmodule

// File: tb/test_flash_prog_seq.sv
module test_flash_prog_seq;
  localparam int AW = 12;
  localparam int NB = 16;
  localparam int SET = 2;
  localparam int PL = 8;
  localparam int BUSY_READS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic op_prog = 1'b0;
  logic busy, done, err_timeout, err_verify;
  logic [3:0] src_addr;
  logic [7:0] src_data;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re;

  always #2 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .BANK_BYTES(NB), .SETTLE_CYC(SET), .POLL_LIMIT(PL)) i_flash_prog_seq (
    .clk(clk), .rst(rst), .start(start), .op_prog(op_prog), .busy(busy), .done(done),
    .err_timeout(err_timeout), .err_verify(err_verify), .src_addr(src_addr), .src_data(src_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;

  // source memory with one cycle of read latency
  logic [7:0] src_mem [0:NB-1];
  always @(posedge clk) src_data <= src_mem[src_addr];

  // flash model
  logic [7:0] mem [0:NB-1];
  logic [AW-1:0] h_a [0:4];
  logic [7:0] h_d [0:4];
  int busy_left = 0;
  logic tog = 1'b0;
  logic hang = 1'b0;
  logic stuck = 1'b0;

  function automatic bit hist(int k, int a, int d);
    return (h_a[k] == AW'(a)) && (h_d[k] == 8'(d));
  endfunction

  always @(posedge clk) begin
    if (fl_we) begin
      if (fl_addr == 0 && fl_wdata == 8'h30 && hist(0, 'h2AA, 'h55) && hist(1, 'h555, 'hAA) &&
          hist(2, 'h555, 'h80) && hist(3, 'h2AA, 'h55) && hist(4, 'h555, 'hAA)) begin
        for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
        busy_left <= BUSY_READS;
      end else if (fl_addr < NB && hist(0, 'h555, 'hA0) && hist(1, 'h2AA, 'h55) && hist(2, 'h555, 'hAA)) begin
        mem[fl_addr[3:0]] <= mem[fl_addr[3:0]] & fl_wdata;
        busy_left <= BUSY_READS;
      end
      for (int k = 4; k > 0; k--) begin h_a[k] <= h_a[k-1]; h_d[k] <= h_d[k-1]; end
      h_a[0] <= fl_addr;
      h_d[0] <= fl_wdata;
    end
    if (fl_re) begin
      if (hang || busy_left > 0) begin
        fl_rdata <= tog ? 8'h40 : 8'h00;
        tog <= ~tog;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end else begin
        fl_rdata <= mem[fl_addr[3:0]] & ((stuck && fl_addr == 5) ? 8'hFE : 8'hFF);
      end
    end
  end

  // bus monitor
  int cyc = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] log_a [0:127];
  logic [7:0] log_d [0:127];
  int log_t [0:127];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fl_we && wr_cnt < 128) begin
      log_a[wr_cnt] <= fl_addr;
      log_d[wr_cnt] <= fl_wdata;
      log_t[wr_cnt] <= cyc;
    end
    if (fl_we) wr_cnt <= wr_cnt + 1;
    if (fl_re) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((i * 37 + seed) & 'hFF);
  endfunction

  function automatic logic [19:0] exp_wr(bit prog, int k, int seed);
    int b;
    int s;
    if (!prog) begin
      case (k)
        0: return {12'h555, 8'hAA};
        1: return {12'h2AA, 8'h55};
        2: return {12'h555, 8'h80};
        3: return {12'h555, 8'hAA};
        4: return {12'h2AA, 8'h55};
        5: return {12'h000, 8'h30};
        default: return {12'h000, 8'hF0};
      endcase
    end
    if (k >= 4 * NB) return {12'h000, 8'hF0};
    b = k / 4;
    s = k % 4;
    case (s)
      0: return {12'h555, 8'hAA};
      1: return {12'h2AA, 8'h55};
      2: return {12'h555, 8'hA0};
      default: return {12'(b), pat(seed, b)};
    endcase
  endfunction

  task automatic load_src(int seed);
    for (int i = 0; i < NB; i++) src_mem[i] = pat(seed, i);
  endtask

  // runs one operation; extra_start pulses start again while busy
  task automatic run(bit prog, bit extra_start, output bit et, output bit ev);
    int w;
    @(negedge clk);
    wr_cnt = 0;
    rd_cnt = 0;
    op_prog = prog;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (10) @(negedge clk);
      op_prog = ~prog;
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      op_prog = prog;
    end
    w = 0;
    while (done !== 1'b1 && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(w < 20000, "R10", "done seen", w, 0);
    check(busy == 1'b0, "R10", "busy low with done", busy, 0);
    et = err_timeout;
    ev = err_verify;
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", done, 0);
    check(err_timeout == et && err_verify == ev, "R10", "errors held", {err_timeout, err_verify}, {et, ev});
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int guard = 0;
    while (guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit et, ev;
    int m;
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    for (int k = 0; k < 5; k++) begin h_a[k] = '0; h_d[k] = '0; end
    fl_rdata = 8'h00;
    load_src(5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && fl_we == 0 && fl_re == 0, "R10", "reset state",
          {busy, done, fl_we, fl_re}, 0);

    // clean erase
    run(1'b0, 1'b0, et, ev);
    check(wr_cnt == 7, "R3", "erase write count", wr_cnt, 7);
    for (int k = 0; k < 7; k++)
      check({log_a[k], log_d[k]} == exp_wr(1'b0, k, 0), k < 6 ? "R1" : "R3", "erase write",
            {log_a[k], log_d[k]}, exp_wr(1'b0, k, 0));
    for (int k = 1; k < 6; k++)
      check(log_t[k] - log_t[k-1] == SET + 2, "R4", "write spacing", log_t[k] - log_t[k-1], SET + 2);
    check(rd_cnt == 2 * (BUSY_READS / 2 + 1) + NB, "R5", "erase read count", rd_cnt, 2 * (BUSY_READS / 2 + 1) + NB);
    check(!et && !ev, "R7", "erase clean flags", {et, ev}, 0);
    for (int i = 0; i < NB; i++) check(mem[i] == 8'hFF, "R7", "erased byte", mem[i], 8'hFF);

    // clean program of pattern A
    run(1'b1, 1'b0, et, ev);
    check(wr_cnt == 4 * NB + 1, "R3", "program write count", wr_cnt, 4 * NB + 1);
    for (int k = 0; k <= 4 * NB; k++)
      check({log_a[k], log_d[k]} == exp_wr(1'b1, k, 5), k < 4 * NB ? "R2" : "R3", "program write",
            {log_a[k], log_d[k]}, exp_wr(1'b1, k, 5));
    check(rd_cnt == NB * 2 * (BUSY_READS / 2 + 1) + NB, "R5", "program read count", rd_cnt, NB * 2 * (BUSY_READS / 2 + 1) + NB);
    check(!et && !ev, "R8", "program clean flags", {et, ev}, 0);
    for (int i = 0; i < NB; i++) check(mem[i] == pat(5, i), "R2", "programmed byte", mem[i], pat(5, i));

    // program pattern B over A without erase: verify must stop at first mismatch
    load_src(8'h9A);
    m = NB;
    for (int i = NB - 1; i >= 0; i--) if ((pat(5, i) & pat(8'h9A, i)) != pat(8'h9A, i)) m = i;
    run(1'b1, 1'b0, et, ev);
    check(ev == (m < NB) && !et, "R8", "program mismatch flag", {et, ev}, {1'b0, m < NB});
    check(rd_cnt == NB * 2 * (BUSY_READS / 2 + 1) + (m < NB ? m + 1 : NB), "R8", "verify stop point",
          rd_cnt, NB * 2 * (BUSY_READS / 2 + 1) + (m < NB ? m + 1 : NB));

    // erase with a stuck bit at offset 5
    stuck = 1'b1;
    run(1'b0, 1'b0, et, ev);
    check(ev && !et, "R7", "erase mismatch flag", {et, ev}, 2'b01);
    check(rd_cnt == 2 * (BUSY_READS / 2 + 1) + 6, "R7", "erase verify stop", rd_cnt, 2 * (BUSY_READS / 2 + 1) + 6);
    stuck = 1'b0;

    // erase that never completes
    hang = 1'b1;
    run(1'b0, 1'b0, et, ev);
    check(et && !ev, "R6", "timeout flag", {et, ev}, 2'b10);
    check(rd_cnt == 2 * PL, "R6", "timeout read count", rd_cnt, 2 * PL);
    check(wr_cnt == 6, "R6", "no write after timeout", wr_cnt, 6);
    hang = 1'b0;

    // erase with a start pulse while busy
    run(1'b0, 1'b1, et, ev);
    check(wr_cnt == 7, "R9", "ignored start write count", wr_cnt, 7);
    for (int k = 0; k < 7; k++)
      check({log_a[k], log_d[k]} == exp_wr(1'b0, k, 0), "R9", "ignored start sequence",
            {log_a[k], log_d[k]}, exp_wr(1'b0, k, 0));
    check(!et && !ev, "R9", "ignored start flags", {et, ev}, 0);
    check(busy == 0, "R9", "idle after run", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule